// File: doc/BRIEF.md
# Hybrid Copy-Tracking Directory Entry

This block holds the sharer record of a single line in a memory-side shared cache. The record tells which first-level caches hold a copy of the line. Each holder is named by its source identifier and by the kind of copy it keeps, which is either an instruction copy or a data copy. The record has a fixed number of explicit slots. While the holders fit in those slots, the record keeps each holder in a slot of its own. The transaction sequencer can then send targeted updates or invalidates to exactly those caches.

A holder may arrive when every slot is already taken. The record then drops all locations and keeps only a running count of copies. In that count mode, any write to the line or eviction of the line must be handled as an invalidate broadcast to every first-level cache; an update is not allowed.

Requests to register a copy and to clean up a copy arrive one per clock cycle with a valid/ready handshake. A combinational query port presents the tracking mode, the count and the slot contents in the same cycle. It also answers whether a given holder must be reached by a coherence action.

Top module: `dir_copy_entry`

## Requirements
- R1: After a synchronous active-high reset, `trk_mode` is 0 (list mode), `copy_count` is 0 and no slot is valid.
- R2: In list mode, a register request (`req_op`=0) for a pair that is not yet present, with at least one slot free, is handled as follows:
  - the pair is written into the lowest-numbered free slot;
  - the slot's `slot_instr` bit is set to 1 for an instruction copy;
  - `copy_count` rises by one and always equals the number of valid slots.
- R3: In count mode (`trk_mode`=1), no slot is valid.
- R4: In list mode, a register request for a new pair that arrives while all SLOTS slots are valid switches the entry to count mode with `copy_count` = SLOTS+1.
- R5: In list mode, registering a (source, type) pair that is already present leaves slots and count unchanged. The same source with the other type counts as a distinct pair.
- R6: In list mode, a cleanup request (`req_op`=1) clears only the slot that matches both source and type, and lowers the count by one. A cleanup with no match changes nothing.
- R7: In count mode, a cleanup lowers `copy_count` by one. When the count reaches zero the entry returns to list mode with no valid slot.
- R8: In count mode, every accepted register request raises `copy_count` by one, without any duplicate check.
- R9: `req_ready` is 0 exactly when a register request is presented in count mode with `copy_count` at its all-ones maximum. A request without `req_valid` and `req_ready` both high changes nothing.
- R10: `qry_holder` responds in the same cycle as its inputs:
  - in list mode it is 1 exactly when a valid slot matches `qry_src`/`qry_instr`;
  - in count mode it is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 1 | 0 register copy, 1 cleanup copy |
| req_src | input | SRC_W | Source identifier of the first-level cache |
| req_instr | input | 1 | 1 instruction copy, 0 data copy |
| qry_src | input | SRC_W | Query source identifier |
| qry_instr | input | 1 | Query copy type |
| qry_holder | output | 1 | Queried cache must be reached by a coherence action |
| trk_mode | output | 1 | 0 list (targeted), 1 count (broadcast invalidate) |
| copy_count | output | CNT_W | Number of copies |
| slot_valid | output | SLOTS | Valid bit per slot |
| slot_src | output | SLOTS*SRC_W | Source identifier per slot, slot i at bits i*SRC_W |
| slot_instr | output | SLOTS | Copy type per slot |

## Verification
Directed sequences cover the following cases:
- they fill the slots with pairs that differ only in copy type, which separates a correct two-field match from one that compares the source alone;
- they free a middle slot and refill it, which shows that the lowest free slot is chosen;
- they overflow into count mode, which confirms the SLOTS+1 count;
- they drain back to zero, which checks the return to list mode.

A long run of registrations drives the count to its maximum, where the handshake must stall registrations but keep accepting cleanups.

Random traffic then draws sources from a small pool, so duplicates, unmatched cleanups and repeated mode switches happen often. Every output and the query answer are compared with a bench model after each cycle.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic {
        TRACK_LIST  = 1'b0,
        TRACK_COUNT = 1'b1
    } track_mode_e;

    typedef enum logic {
        OP_REGISTER = 1'b0,
        OP_CLEANUP  = 1'b1
    } copy_op_e;

    // true when a count of the given width sits at its all-ones value
    function automatic logic cnt_is_max(input logic [31:0] cnt, input int unsigned width);
        logic [31:0] lim;
        lim = (32'd1 << width) - 32'd1;
        return cnt == lim;
    endfunction

endpackage

// File: rtl/dir_slot_match.sv
module dir_slot_match #(
    parameter int unsigned SLOTS = 4,
    parameter int unsigned SRC_W = 6
) (
    input  logic [SLOTS-1:0]            vld,
    input  logic [SLOTS-1:0][SRC_W-1:0] src,
    input  logic [SLOTS-1:0]            ins,
    input  logic [SRC_W-1:0]            key_src,
    input  logic                        key_ins,
    output logic [SLOTS-1:0]            hit_vec,
    output logic                        hit_any
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (src[g] == key_src) && (ins[g] == key_ins);
    end

    assign hit_any = |hit_vec;
endmodule

// File: rtl/dir_slot_alloc.sv
module dir_slot_alloc #(
    parameter int unsigned SLOTS = 4
) (
    input  logic [SLOTS-1:0] vld,
    output logic [SLOTS-1:0] free_vec,
    output logic             any_free
);
    logic found;

    always_comb begin
        free_vec = '0;
        found    = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!vld[i] && !found) begin
                free_vec[i] = 1'b1;
                found       = 1'b1;
            end
        end
    end

    assign any_free = found;
endmodule

// File: rtl/dir_next_state.sv
module dir_next_state
    import dir_pkg::*;
#(
    parameter int unsigned SLOTS = 4,
    parameter int unsigned SRC_W = 6,
    parameter int unsigned CNT_W = 8
) (
    input  track_mode_e                 mode_q,
    input  logic [CNT_W-1:0]            cnt_q,
    input  logic [SLOTS-1:0]            vld_q,
    input  logic [SLOTS-1:0][SRC_W-1:0] src_q,
    input  logic [SLOTS-1:0]            ins_q,
    input  logic                        fire,
    input  copy_op_e                    op,
    input  logic [SRC_W-1:0]            key_src,
    input  logic                        key_ins,
    input  logic [SLOTS-1:0]            hit_vec,
    input  logic                        hit_any,
    input  logic [SLOTS-1:0]            free_vec,
    input  logic                        any_free,
    output track_mode_e                 mode_d,
    output logic [CNT_W-1:0]            cnt_d,
    output logic [SLOTS-1:0]            vld_d,
    output logic [SLOTS-1:0][SRC_W-1:0] src_d,
    output logic [SLOTS-1:0]            ins_d
);
    localparam logic [CNT_W-1:0] OVF_CNT = CNT_W'(SLOTS + 1);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    always_comb begin
        mode_d = mode_q;
        cnt_d  = cnt_q;
        vld_d  = vld_q;
        src_d  = src_q;
        ins_d  = ins_q;
        if (fire) begin
            if (mode_q == TRACK_LIST) begin
                if (op == OP_REGISTER) begin
                    if (!hit_any) begin
                        if (any_free) begin
                            for (int i = 0; i < SLOTS; i++) begin
                                if (free_vec[i]) begin
                                    vld_d[i] = 1'b1;
                                    src_d[i] = key_src;
                                    ins_d[i] = key_ins;
                                end
                            end
                            cnt_d = cnt_q + ONE;
                        end else begin
                            mode_d = TRACK_COUNT;
                            cnt_d  = OVF_CNT;
                            vld_d  = '0;
                        end
                    end
                end else if (hit_any) begin
                    vld_d = vld_q & ~hit_vec;
                    cnt_d = cnt_q - ONE;
                end
            end else begin
                if (op == OP_REGISTER) begin
                    cnt_d = cnt_q + ONE;
                end else begin
                    cnt_d = cnt_q - ONE;
                    if (cnt_q == ONE) begin
                        mode_d = TRACK_LIST;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/dir_copy_entry.sv
module dir_copy_entry
    import dir_pkg::*;
#(
    parameter int unsigned SLOTS = 4,
    parameter int unsigned SRC_W = 6,
    parameter int unsigned CNT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_op,
    input  logic [SRC_W-1:0]       req_src,
    input  logic                   req_instr,
    input  logic [SRC_W-1:0]       qry_src,
    input  logic                   qry_instr,
    output logic                   qry_holder,
    output logic                   trk_mode,
    output logic [CNT_W-1:0]       copy_count,
    output logic [SLOTS-1:0]       slot_valid,
    output logic [SLOTS*SRC_W-1:0] slot_src,
    output logic [SLOTS-1:0]       slot_instr
);
    track_mode_e                 mode_q, mode_d;
    logic [CNT_W-1:0]            cnt_q, cnt_d;
    logic [SLOTS-1:0]            vld_q, vld_d;
    logic [SLOTS-1:0][SRC_W-1:0] src_q, src_d;
    logic [SLOTS-1:0]            ins_q, ins_d;

    logic [SLOTS-1:0] req_hit_vec, qry_hit_vec, free_vec;
    logic             req_hit_any, qry_hit_any, any_free;
    logic             fire, at_max;
    copy_op_e         op;

    assign op     = copy_op_e'(req_op);
    assign at_max = cnt_is_max(32'(cnt_q), CNT_W);

    // a registration in count mode is held off only when the count cannot grow
    assign req_ready = !((op == OP_REGISTER) && (mode_q == TRACK_COUNT) && at_max);
    assign fire      = req_valid && req_ready;

    dir_slot_match #(.SLOTS(SLOTS), .SRC_W(SRC_W)) u_req_match (
        .vld(vld_q), .src(src_q), .ins(ins_q),
        .key_src(req_src), .key_ins(req_instr),
        .hit_vec(req_hit_vec), .hit_any(req_hit_any)
    );

    dir_slot_match #(.SLOTS(SLOTS), .SRC_W(SRC_W)) u_qry_match (
        .vld(vld_q), .src(src_q), .ins(ins_q),
        .key_src(qry_src), .key_ins(qry_instr),
        .hit_vec(qry_hit_vec), .hit_any(qry_hit_any)
    );

    dir_slot_alloc #(.SLOTS(SLOTS)) u_alloc (
        .vld(vld_q), .free_vec(free_vec), .any_free(any_free)
    );

    dir_next_state #(.SLOTS(SLOTS), .SRC_W(SRC_W), .CNT_W(CNT_W)) u_next (
        .mode_q(mode_q), .cnt_q(cnt_q), .vld_q(vld_q), .src_q(src_q), .ins_q(ins_q),
        .fire(fire), .op(op), .key_src(req_src), .key_ins(req_instr),
        .hit_vec(req_hit_vec), .hit_any(req_hit_any),
        .free_vec(free_vec), .any_free(any_free),
        .mode_d(mode_d), .cnt_d(cnt_d), .vld_d(vld_d), .src_d(src_d), .ins_d(ins_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= TRACK_LIST;
            cnt_q  <= '0;
            vld_q  <= '0;
            src_q  <= '0;
            ins_q  <= '0;
        end else begin
            mode_q <= mode_d;
            cnt_q  <= cnt_d;
            vld_q  <= vld_d;
            src_q  <= src_d;
            ins_q  <= ins_d;
        end
    end

    // count mode has no locations, so every cache is a potential holder
    assign qry_holder = (mode_q == TRACK_COUNT) ? 1'b1 : qry_hit_any;
    assign trk_mode   = mode_q;
    assign copy_count = cnt_q;
    assign slot_valid = vld_q;
    assign slot_instr = ins_q;

    for (genvar g = 0; g < SLOTS; g++) begin : g_flat
        assign slot_src[g*SRC_W +: SRC_W] = src_q[g];
    end
endmodule

// File: rtl/dir_copy_entry_chk.sv
module dir_copy_entry_chk #(
    parameter int unsigned SLOTS = 4,
    parameter int unsigned SRC_W = 6,
    parameter int unsigned CNT_W = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic                   req_op,
    input logic [SRC_W-1:0]       req_src,
    input logic                   req_instr,
    input logic                   qry_holder,
    input logic                   trk_mode,
    input logic [CNT_W-1:0]       copy_count,
    input logic [SLOTS-1:0]       slot_valid,
    input logic [SLOTS*SRC_W-1:0] slot_src,
    input logic [SLOTS-1:0]       slot_instr
);
    localparam logic [CNT_W-1:0] OVF_CNT = CNT_W'(SLOTS + 1);
    localparam logic [CNT_W-1:0] MAX_CNT = {CNT_W{1'b1}};

    logic [SLOTS-1:0] c_hit;
    logic             c_any, c_fire;

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            c_hit[i] = slot_valid[i] && (slot_src[i*SRC_W +: SRC_W] == req_src)
                       && (slot_instr[i] == req_instr);
        end
    end
    assign c_any  = |c_hit;
    assign c_fire = req_valid && req_ready;

    p_list_count_r2: assert property (@(posedge clk) disable iff (rst)
        !trk_mode |-> ($countones(slot_valid) == int'(copy_count)));

    p_count_noslot_r3: assert property (@(posedge clk) disable iff (rst)
        trk_mode |-> (slot_valid == '0));

    p_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        (c_fire && !req_op && !trk_mode && (&slot_valid) && !c_any)
        |=> (trk_mode && copy_count == OVF_CNT));

    p_dup_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (c_fire && !req_op && !trk_mode && c_any)
        |=> ($stable(slot_valid) && $stable(copy_count) && !trk_mode));

    p_clean_list_r6: assert property (@(posedge clk) disable iff (rst)
        (c_fire && req_op && !trk_mode)
        |=> (slot_valid == ($past(slot_valid) & ~$past(c_hit))));

    p_count_dec_r7: assert property (@(posedge clk) disable iff (rst)
        (c_fire && req_op && trk_mode && copy_count > 1)
        |=> (trk_mode && copy_count == $past(copy_count) - 1'b1));

    p_count_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (c_fire && req_op && trk_mode && copy_count == 1)
        |=> (!trk_mode && copy_count == '0 && slot_valid == '0));

    p_count_inc_r8: assert property (@(posedge clk) disable iff (rst)
        (c_fire && !req_op && trk_mode)
        |=> (trk_mode && copy_count == $past(copy_count) + 1'b1));

    p_stall_sat_r9: assert property (@(posedge clk) disable iff (rst)
        (trk_mode && copy_count == MAX_CNT && !req_op) |-> !req_ready);

    p_cleanup_ready_r9: assert property (@(posedge clk) disable iff (rst)
        req_op |-> req_ready);

    p_query_bcast_r10: assert property (@(posedge clk) disable iff (rst)
        trk_mode |-> qry_holder);
endmodule

bind dir_copy_entry dir_copy_entry_chk #(
    .SLOTS(SLOTS), .SRC_W(SRC_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_src(req_src), .req_instr(req_instr),
    .qry_holder(qry_holder), .trk_mode(trk_mode), .copy_count(copy_count),
    .slot_valid(slot_valid), .slot_src(slot_src), .slot_instr(slot_instr)
);

// File: tb/dir_copy_entry_tb_top.sv
`timescale 1ns/1ps
module dir_copy_entry_tb_top;
    localparam int SLOTS = 4;
    localparam int SRC_W = 6;
    localparam int CNT_W = 8;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_op = 1'b0, req_instr = 1'b0, qry_instr = 1'b0;
    logic [SRC_W-1:0] req_src = '0, qry_src = '0;
    logic req_ready, qry_holder, trk_mode;
    logic [CNT_W-1:0] copy_count;
    logic [SLOTS-1:0] slot_valid, slot_instr;
    logic [SLOTS*SRC_W-1:0] slot_src;

    always #2 clk = ~clk;

    dir_copy_entry #(.SLOTS(SLOTS), .SRC_W(SRC_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_src(req_src), .req_instr(req_instr),
        .qry_src(qry_src), .qry_instr(qry_instr), .qry_holder(qry_holder),
        .trk_mode(trk_mode), .copy_count(copy_count), .slot_valid(slot_valid),
        .slot_src(slot_src), .slot_instr(slot_instr)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // bench model of the entry
    bit m_mode;
    int m_cnt;
    bit m_vld[SLOTS];
    int m_src[SLOTS];
    bit m_ins[SLOTS];

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int m_find(int s, bit i);
        for (int k = 0; k < SLOTS; k++)
            if (m_vld[k] && m_src[k] == s && m_ins[k] == i) return k;
        return -1;
    endfunction

    function automatic bit m_ready(bit op);
        return !(op == 1'b0 && m_mode && m_cnt == CMAX);
    endfunction

    function automatic bit m_holder(int s, bit i);
        return m_mode ? 1'b1 : (m_find(s, i) >= 0);
    endfunction

    task automatic m_reset();
        m_mode = 0; m_cnt = 0;
        for (int k = 0; k < SLOTS; k++) begin m_vld[k] = 0; m_src[k] = 0; m_ins[k] = 0; end
    endtask

    task automatic m_apply(bit op, int s, bit i);
        int f;
        f = m_find(s, i);
        if (!m_mode) begin
            if (!op) begin
                if (f < 0) begin
                    int fr = -1;
                    for (int k = SLOTS - 1; k >= 0; k--) if (!m_vld[k]) fr = k;
                    if (fr >= 0) begin
                        m_vld[fr] = 1; m_src[fr] = s; m_ins[fr] = i; m_cnt++;
                    end else begin
                        m_mode = 1; m_cnt = SLOTS + 1;
                        for (int k = 0; k < SLOTS; k++) m_vld[k] = 0;
                    end
                end
            end else if (f >= 0) begin
                m_vld[f] = 0; m_cnt--;
            end
        end else begin
            if (!op) m_cnt++;
            else begin
                m_cnt--;
                if (m_cnt == 0) m_mode = 0;
            end
        end
    endtask

    task automatic check_state(string req);
        longint ev = 0, es = 0, as = 0;
        for (int k = 0; k < SLOTS; k++) begin
            if (m_vld[k]) begin
                ev |= (longint'(1) << k);
                es |= (longint'(m_src[k]) << (k * (SRC_W + 1))) | (longint'(m_ins[k]) << (k * (SRC_W + 1) + SRC_W));
            end
            if (slot_valid[k])
                as |= (longint'(slot_src[k*SRC_W +: SRC_W]) << (k * (SRC_W + 1)))
                    | (longint'(slot_instr[k]) << (k * (SRC_W + 1) + SRC_W));
        end
        chk(trk_mode === m_mode, req, "mode", trk_mode, m_mode);
        chk(copy_count === CNT_W'(m_cnt), req, "count", copy_count, m_cnt);
        chk(slot_valid === SLOTS'(ev), req, "slot_valid", slot_valid, ev);
        chk(as == es, req, "slot contents", as, es);
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(bit v, bit op, int s, bit i, int qs, bit qi, string req);
        bit exp_rdy;
        req_valid = v; req_op = op; req_src = SRC_W'(s); req_instr = i;
        qry_src = SRC_W'(qs); qry_instr = qi;
        #1;
        exp_rdy = m_ready(op);
        chk(req_ready === exp_rdy, "R9", "ready", req_ready, exp_rdy);
        chk(qry_holder === m_holder(qs, qi), "R10", "holder", qry_holder, m_holder(qs, qi));
        @(posedge clk);
        if (v && exp_rdy) m_apply(op, s, i);
        @(negedge clk);
        req_valid = 0;
        check_state(req);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        chk(1'b0, "WATCHDOG", "timeout", 0, 1);
        finish_run();
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check_state("R1");

        // R2 / R5: same source with both types, then a duplicate
        step(1, 0, 3, 0, 3, 0, "R2");
        step(1, 0, 3, 1, 3, 1, "R5");
        step(1, 0, 3, 0, 3, 1, "R5");
        step(1, 0, 7, 0, 7, 1, "R2");
        step(1, 0, 9, 1, 9, 1, "R2");
        // R6: cleanup a middle slot, then an unmatched cleanup
        step(1, 1, 7, 0, 7, 0, "R6");
        step(1, 1, 20, 0, 3, 0, "R6");
        step(1, 1, 9, 0, 9, 1, "R6");
        // R2: refill lowest free slot
        step(1, 0, 11, 0, 11, 0, "R2");
        // no-valid request has no effect (R9)
        step(0, 0, 40, 0, 40, 0, "R9");
        // R4: fifth distinct holder
        step(1, 0, 12, 1, 12, 1, "R4");
        step(0, 0, 0, 0, 33, 0, "R3");
        // R8: count mode increments, duplicates too
        step(1, 0, 12, 1, 1, 1, "R8");
        step(1, 0, 12, 1, 1, 1, "R8");
        // R7: drain to zero and back to list mode
        for (int k = 0; k < 7; k++) step(1, 1, k, 0, 5, 0, "R7");
        step(0, 0, 0, 0, 5, 0, "R7");

        // R9: saturate the count
        for (int k = 0; k < 5; k++) step(1, 0, k, 0, 0, 0, "R4");
        while (m_cnt < CMAX) step(1, 0, 1, 1, 2, 0, "R8");
        step(1, 0, 8, 0, 8, 0, "R9");
        step(1, 0, 8, 1, 8, 0, "R9");
        step(1, 1, 8, 0, 8, 0, "R9");
        while (m_cnt > 0) step(1, 1, 2, 0, 2, 0, "R7");

        // random traffic over a small source pool
        void'($urandom(32'h5eed1234));
        for (int n = 0; n < 4000; n++) begin
            bit v, op, i, qi;
            int s, qs;
            v  = ($urandom % 8) != 0;
            op = ($urandom % 100) < ((m_mode && m_cnt > 12) ? 70 : 45);
            s  = $urandom % 6;
            i  = $urandom % 2;
            qs = $urandom % 6;
            qi = $urandom % 2;
            step(v, op, s, i, qs, qi, "R2");
        end

        finish_run();
    end
endmodule